// File: doc/BRIEF.md
# Halfword Multiply-Subtract Accumulator

This execution unit carries out one multiply-subtract step of a fixed-point signal-processing instruction. Each step picks one 16-bit halfword out of each of two 32-bit source values and multiplies the two halfwords. It then subtracts the product from a 64-bit accumulator that the unit holds itself. The new 64-bit value replaces the accumulator. Its low 32 bits are also returned as a destination-register result.

The operands can be signed or unsigned. A mode bit selects integer or fraction arithmetic. In fraction mode the upper halfwords are used and the product is doubled to align a Q15 result. An optional rounding flag adds half of a 16-bit step before the subtraction. Overflow wraps modulo 2^64 and raises no exception.

Operations arrive on a valid/ready issue port. Results leave on a valid/ready result port. The unit accepts an issue only when its result slot is empty or is being drained in the same cycle, and a held result stays unchanged until it is taken. A separate load port writes the accumulator directly for test set-up.

Top module: `hmsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator becomes 0 and `out_valid` becomes 0 at that edge.
- R2: With `frac_mode`=0, the operands are bits [15:0] of each source and the product is used unshifted: acc_new = acc - product.
- R3: With `frac_mode`=1, the operands are bits [31:16] of each source and the product is shifted left by one bit before it is subtracted.
- R4: With `is_signed`=1, both halfwords are two's complement and the 32-bit product is sign-extended to 64 bits. With `is_signed`=0, both halfwords are unsigned and the product is zero-extended.
- R5: With `round_en`=1, the constant 0x8000 is added to the (possibly shifted) product before the subtraction. With `round_en`=0, nothing is added.
- R6: `dest_out` equals bits [31:0] of the new accumulator value produced by the same operation.
- R7: The subtraction wraps modulo 2^64. For example, 0 - 4 gives 0xFFFF_FFFF_FFFF_FFFC.
- R8: An issue is accepted at an edge where `in_valid` and `in_ready` are both 1. At that same edge `acc_out`, `dest_out` and `out_valid`=1 are updated, so they are visible one cycle after the issue.
- R9: `in_ready` = !`ld_en` && (!`out_valid` || `out_ready`). While `out_valid`=1 and `out_ready`=0, `out_valid`, `dest_out` and the accumulator stay unchanged, and any offered issue is not taken.
- R10: When `ld_en`=1 at an edge, the accumulator takes `ld_value` at that edge. Load has priority over issue: no issue is accepted in that cycle.
- R11: At an edge with neither an accepted issue nor a load, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Unit can accept an issue |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| is_signed | input | 1 | 1 = signed halfwords, 0 = unsigned |
| round_en | input | 1 | 1 = add 0x8000 before subtracting |
| frac_mode | input | 1 | 1 = fraction mode (upper halfwords, doubled), 0 = integer mode |
| ld_en | input | 1 | Direct accumulator load strobe |
| ld_value | input | 64 | Value for direct load |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | 64 | Current accumulator contents |
| dest_out | output | 32 | Destination-register result of the last operation |

## Verification
Each accepted issue produces its accumulator, destination and valid values exactly one clock edge later, and a direct load is also visible one edge after `ld_en`. The bench drives every input on the falling edge and checks results on the next falling edge, so each check sits one half-period after the edge that made the result. During a stall the bench samples on several consecutive falling edges to show that the result is held. It then releases `out_ready` and checks the pending issue one edge after acceptance.

// File: rtl/hmsub_pkg.sv
package hmsub_pkg;
  typedef struct packed {
    logic is_signed;
    logic round_en;
    logic frac_mode;
  } op_ctl_t;
endpackage

// File: rtl/hmsub_halfsel.sv
module hmsub_halfsel #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word_in,
  input  logic                take_upper,
  output logic [HALF_W-1:0]   half_out
);
  always_comb begin
    if (take_upper) half_out = word_in[2*HALF_W-1:HALF_W];
    else            half_out = word_in[HALF_W-1:0];
  end
endmodule

// File: rtl/hmsub_term.sv
module hmsub_term
  import hmsub_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   opa,
  input  logic [HALF_W-1:0]   opb,
  input  op_ctl_t             ctl,
  output logic [4*HALF_W-1:0] subtrahend
);
  localparam int PW = 2 * HALF_W;
  localparam int AW = 4 * HALF_W;

  logic [PW-1:0] ext_a, ext_b, prod;
  logic [AW-1:0] prod_wide, aligned, rnd_const;

  assign rnd_const = {{(AW-1){1'b0}}, 1'b1} << (HALF_W - 1);

  always_comb begin
    ext_a = {{HALF_W{ctl.is_signed & opa[HALF_W-1]}}, opa};
    ext_b = {{HALF_W{ctl.is_signed & opb[HALF_W-1]}}, opb};
    prod  = ext_a * ext_b;
    prod_wide = {{PW{ctl.is_signed & prod[PW-1]}}, prod};
    aligned = ctl.frac_mode ? (prod_wide << 1) : prod_wide;
    subtrahend = ctl.round_en ? (aligned + rnd_const) : aligned;
  end
endmodule

// File: rtl/hmsub_unit.sv
module hmsub_unit
  import hmsub_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*HALF_W-1:0] src_a,
  input  logic [2*HALF_W-1:0] src_b,
  input  logic                is_signed,
  input  logic                round_en,
  input  logic                frac_mode,
  input  logic                ld_en,
  input  logic [4*HALF_W-1:0] ld_value,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*HALF_W-1:0] acc_out,
  output logic [2*HALF_W-1:0] dest_out
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = 4 * HALF_W;

  op_ctl_t ctl;
  logic [1:0][WORD_W-1:0] srcs;
  logic [1:0][HALF_W-1:0] halves;
  logic [ACC_W-1:0] sub_term, acc_next, acc_q;
  logic [WORD_W-1:0] dest_q;
  logic ov_q, fire;

  assign ctl  = '{is_signed: is_signed, round_en: round_en, frac_mode: frac_mode};
  assign srcs = {src_b, src_a};

  for (genvar k = 0; k < 2; k++) begin : g_sel
    hmsub_halfsel #(.HALF_W(HALF_W)) u_sel (
      .word_in(srcs[k]), .take_upper(frac_mode), .half_out(halves[k])
    );
  end

  hmsub_term #(.HALF_W(HALF_W)) u_term (
    .opa(halves[0]), .opb(halves[1]), .ctl(ctl), .subtrahend(sub_term)
  );

  assign acc_next = acc_q - sub_term;
  assign in_ready = !ld_en && (!ov_q || out_ready);
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      dest_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (ld_en) begin
        acc_q <= ld_value;
      end else if (fire) begin
        acc_q  <= acc_next;
        dest_q <= acc_next[WORD_W-1:0];
      end
      if (fire)           ov_q <= 1'b1;
      else if (out_ready) ov_q <= 1'b0;
    end
  end

  assign acc_out   = acc_q;
  assign dest_out  = dest_q;
  assign out_valid = ov_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !ov_q));

  // R6
  dest_matches_acc_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (ov_q && dest_q == acc_q[WORD_W-1:0]));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready && !ld_en) |=> (ov_q && $stable(dest_q) && $stable(acc_q)));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (acc_q == $past(ld_value)));

  // R11
  idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && !ld_en) |=> $stable(acc_q));
endmodule

// File: tb/sim_hmsub_unit.sv
module sim_hmsub_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, is_signed = 0, round_en = 0, frac_mode = 0;
  logic ld_en = 0, out_ready = 1;
  logic [31:0] src_a = '0, src_b = '0;
  logic [63:0] ld_value = '0;
  logic in_ready, out_valid;
  logic [63:0] acc_out;
  logic [31:0] dest_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hmsub_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .is_signed(is_signed), .round_en(round_en),
    .frac_mode(frac_mode), .ld_en(ld_en), .ld_value(ld_value),
    .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out), .dest_out(dest_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] acc, input logic [31:0] a, input logic [31:0] b,
                                        input bit s, input bit r, input bit f);
    logic [15:0] x, y;
    logic [63:0] xe, ye, p;
    x = f ? a[31:16] : a[15:0];
    y = f ? b[31:16] : b[15:0];
    xe = s ? {{48{x[15]}}, x} : {48'h0, x};
    ye = s ? {{48{y[15]}}, y} : {48'h0, y};
    p = xe * ye;
    if (f) p = p << 1;
    if (r) p = p + 64'h8000;
    return acc - p;
  endfunction

  task automatic set_op(input logic [31:0] a, input logic [31:0] b, input bit s, input bit r, input bit f);
    src_a = a; src_b = b; is_signed = s; round_en = r; frac_mode = f;
  endtask

  task automatic run_op(input logic [63:0] init, input logic [31:0] a, input logic [31:0] b,
                        input bit s, input bit r, input bit f, input string tag);
    logic [63:0] e;
    @(negedge clk); ld_en = 1; ld_value = init; in_valid = 0;
    @(negedge clk); ld_en = 0; in_valid = 1; set_op(a, b, s, r, f);
    @(negedge clk); in_valid = 0;
    e = model(init, a, b, s, r, f);
    chk(out_valid == 1'b1, "R8 out_valid", 64'(out_valid), 64'd1);
    chk(acc_out == e, tag, acc_out, e);
    chk(dest_out == e[31:0], "R6 dest", 64'(dest_out), 64'(e[31:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] hv [6];
    logic [63:0] inits [3];
    logic [63:0] a1, e;
    logic [31:0] d1;
    hv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    inits = '{64'h0, 64'h7FFF_FFFF_0000_1111, 64'h0123_4567_89AB_CDEF};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(acc_out == 64'h0, "R1 acc", acc_out, 64'h0);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'h0);
    rst = 0;
    @(negedge clk);
    #1 chk(in_ready == 1'b1, "R9 ready idle", 64'(in_ready), 64'd1);

    // R2 R3 R4 R5 sweep of halfword values, signedness, rounding and mode
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int m = 0; m < 8; m++) begin
          string tag;
          tag = {(m[2] ? "R3" : "R2"), (m[0] ? " R4 signed" : " R4 unsigned"), (m[1] ? " R5 rnd" : " R5 none")};
          run_op(inits[(i + j) % 3], {hv[i], hv[(i + 3) % 6]}, {hv[j], hv[(j + 2) % 6]},
                 m[0], m[1], m[2], tag);
        end

    // R7 wrap below zero
    run_op(64'h0, 32'h0000_0002, 32'h0000_0002, 0, 0, 0, "R7 wrap");
    chk(acc_out == 64'hFFFF_FFFF_FFFF_FFFC, "R7 wrap value", acc_out, 64'hFFFF_FFFF_FFFF_FFFC);

    // R9 back-pressure
    @(negedge clk); ld_en = 1; ld_value = 64'd1000; out_ready = 0;
    @(negedge clk); ld_en = 0; in_valid = 1; set_op(32'h0000_0003, 32'h0000_0005, 0, 0, 0);
    @(negedge clk); set_op(32'h0000_0007, 32'h0000_0002, 0, 0, 0);
    #1 chk(in_ready == 1'b0, "R9 ready low in stall", 64'(in_ready), 64'd0);
    chk(out_valid == 1'b1, "R9 valid", 64'(out_valid), 64'd1);
    chk(acc_out == 64'd985, "R9 first result", acc_out, 64'd985);
    a1 = acc_out; d1 = dest_out;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid held", 64'(out_valid), 64'd1);
    chk(dest_out == d1, "R9 dest held", 64'(dest_out), 64'(d1));
    chk(acc_out == a1, "R9 issue not taken", acc_out, a1);
    out_ready = 1;
    @(negedge clk); in_valid = 0;
    e = model(a1, 32'h0000_0007, 32'h0000_0002, 0, 0, 0);
    chk(acc_out == e, "R8 after release", acc_out, e);
    chk(out_valid == 1'b1, "R8 valid after release", 64'(out_valid), 64'd1);

    // R10 load priority over issue
    @(negedge clk); ld_en = 1; ld_value = 64'hDEAD_BEEF_0000_0042; in_valid = 1;
    set_op(32'h0000_0009, 32'h0000_0009, 0, 0, 0);
    #1 chk(in_ready == 1'b0, "R10 ready low on load", 64'(in_ready), 64'd0);
    @(negedge clk); ld_en = 0; in_valid = 0;
    chk(acc_out == 64'hDEAD_BEEF_0000_0042, "R10 load value", acc_out, 64'hDEAD_BEEF_0000_0042);
    chk(out_valid == 1'b0, "R10 no issue taken", 64'(out_valid), 64'd0);

    // R11 idle keeps accumulator
    repeat (3) @(negedge clk);
    chk(acc_out == 64'hDEAD_BEEF_0000_0042, "R11 idle", acc_out, 64'hDEAD_BEEF_0000_0042);

    // R1 reset mid-run
    rst = 1;
    @(negedge clk); rst = 0;
    chk(acc_out == 64'h0, "R1 mid-run reset", acc_out, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule